// File: doc/BRIEF.md
# Ring Resync Full-Descriptor Scanner

This block recovers the software consumer position on a circular receive descriptor ring after the fill engine has stepped past one or more descriptors. The engine fills descriptors in order. Once it has judged a descriptor unusable, it resumes at the one after it. That leaves empty "holes" behind it. A consumer sitting on such a hole waits forever while later descriptors are already full. When a receive interrupt is pending, the surrounding logic pulses a start strobe together with the current consumer index. The block then reads the status word at that index through a one-cycle-latency read port into the status memory. If that descriptor is empty, the block walks forward around the ring, one descriptor per cycle. It stops at the first descriptor whose status says full.

On completion the block pulses a done strobe and raises a found flag. It also presents the index at which the consumer should resume, as both its new tail and its new head. If the consumer descriptor turns out not to be empty, no resync is needed. If a full lap of the ring holds no full descriptor, nothing can be recovered. In both of these cases the block finishes with the found flag low and hands back the original index.

Top module: `rsync_scan`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `found_o` and `rd_en_o` are low and `new_idx_o` is zero until the first accepted start.
- R2: A start strobe is accepted only while the block is idle and `irq_pend_i` is high. A strobe with `irq_pend_i` low causes no read, no done pulse and no change of `found_o` or `new_idx_o`.
- R3: After an accepted start, the first read address is the given tail index. Each following cycle reads the next index, and the index wraps from 255 to 0.
- R4: The status code sits in bits [31:28] of each status word: 0xA empty, 0x4 full, 0xF not in use. If the descriptor at the tail is anything but empty, the scan ends with `found_o` low and `new_idx_o` equal to the tail.
- R5: If the tail descriptor is empty, the block reports the first descriptor at ring offset k (1 to 255) from the tail whose code is full. It sets `found_o` high and `new_idx_o` to (tail + k) mod 256. Empty and not-in-use descriptors before it are skipped.
- R6: If the tail is empty and none of the 256 descriptors is full, the scan ends with `found_o` low, `new_idx_o` equal to the tail, and exactly 256 reads issued.
- R7: `done_o` is high for exactly one cycle per accepted start. Count the accepting clock edge as edge 0 and let k be the offset of the deciding descriptor (0 for R4, 255 for R6). Then `done_o` is high in the cycle after edge k+2.
- R8: A start strobe that arrives while a scan is running is ignored. The running scan keeps its tail and its result.
- R9: `found_o` and `new_idx_o` change only together with a done pulse. They hold their value between pulses.
- R10: Reads stop once the outcome is decided. A scan issues k+2 reads when it decides at offset k below 255, and never more than 256 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend_i | input | 1 | A receive interrupt is pending |
| start_i | input | 1 | Request a resync scan |
| tail_i | input | 8 | Current consumer tail index |
| rd_en_o | output | 1 | Status memory read enable |
| rd_addr_o | output | 8 | Status memory read index |
| rd_data_i | input | 32 | Status word, valid the cycle after the read |
| done_o | output | 1 | One-cycle scan completion pulse |
| found_o | output | 1 | A full descriptor was located |
| new_idx_o | output | 8 | Resume index for tail and head |

## Verification
Most internal faults show up first on the read port. If the issue counter goes astray, the read address sequence departs from tail, tail+1, and so on, in the very next cycle. It can also run past the 256-read lap or keep reading after the decision. If the response offset slips against the read data, the block reports a neighbour of the true full descriptor, or its done pulse lands one cycle early or late. This shows at the single done pulse. If the tail is latched incorrectly or restarted by a stray start, the reads go to the wrong addresses and the reported index comes out wrong. Checks of the read sequence, the latency of each done pulse and the held result therefore expose these faults within one scan.

// File: rtl/rsync_pkg.sv
package rsync_pkg;

    // Width of the status code field at the top of each status word.
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] ST_EMPTY  = 4'hA;
    localparam logic [CODE_W-1:0] ST_FULL   = 4'h4;
    localparam logic [CODE_W-1:0] ST_PARKED = 4'hF;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;

    typedef struct packed {
        logic empty;
        logic full;
        logic parked;
    } class_t;

endpackage

// File: rtl/rsync_classify.sv
module rsync_classify
    import rsync_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic [STAT_W-1:0] word_i,
    output class_t            cls_o
);

    localparam int LOW_W = STAT_W - CODE_W;

    logic [CODE_W-1:0] code;
    logic              unused_low;

    assign code       = word_i[STAT_W-1 -: CODE_W];
    assign unused_low = ^word_i[LOW_W-1:0];

    always_comb begin
        cls_o        = '0;
        cls_o.empty  = (code == ST_EMPTY);
        cls_o.full   = (code == ST_FULL);
        cls_o.parked = (code == ST_PARKED);
    end

endmodule

// File: rtl/rsync_issue.sv
module rsync_issue #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic [IDX_W-1:0] tail_i,
    input  logic             kill_i,
    output logic             rd_en_o,
    output logic [IDX_W-1:0] rd_addr_o
);

    localparam int RING  = 1 << IDX_W;
    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] CNT_LAP = CNT_W'(RING);

    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] addr;
        logic [CNT_W-1:0] cnt;
    } iss_t;

    iss_t iss_d, iss_q;

    always_comb begin
        iss_d = iss_q;
        if (kill_i) begin
            iss_d.act = 1'b0;
        end else if (launch_i) begin
            iss_d.act  = 1'b1;
            iss_d.addr = tail_i;
            iss_d.cnt  = CNT_W'(1);
        end else if (iss_q.act) begin
            if (iss_q.cnt == CNT_LAP) begin
                iss_d.act = 1'b0;
            end else begin
                iss_d.addr = iss_q.addr + 1'b1;
                iss_d.cnt  = iss_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    assign rd_en_o   = iss_q.act;
    assign rd_addr_o = iss_q.addr;

    // R10
    issue_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_q.act |-> (iss_q.cnt != '0) && (iss_q.cnt <= CNT_LAP));

endmodule

// File: rtl/rsync_track.sv
module rsync_track #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             rd_en_i,
    output logic             resp_vld_o,
    output logic [IDX_W-1:0] resp_off_o
);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] off;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d     = trk_q;
        trk_d.vld = rd_en_i;
        if (launch_i)       trk_d.off = '0;
        else if (trk_q.vld) trk_d.off = trk_q.off + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign resp_vld_o = trk_q.vld;
    assign resp_off_o = trk_q.off;

endmodule

// File: rtl/rsync_scan.sv
module rsync_scan
    import rsync_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pend_i,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  tail_i,
    output logic              rd_en_o,
    output logic [IDX_W-1:0]  rd_addr_o,
    input  logic [STAT_W-1:0] rd_data_i,
    output logic              done_o,
    output logic              found_o,
    output logic [IDX_W-1:0]  new_idx_o
);

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] tail;
        logic             done;
        logic             found;
        logic [IDX_W-1:0] idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             launch;
    logic             kill;
    logic             resp_vld;
    logic [IDX_W-1:0] resp_off;
    class_t           cls;
    logic             at_tail;
    logic             last_off;

    rsync_issue #(.IDX_W(IDX_W)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .tail_i    (tail_i),
        .kill_i    (kill),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o)
    );

    rsync_track #(.IDX_W(IDX_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .rd_en_i    (rd_en_o),
        .resp_vld_o (resp_vld),
        .resp_off_o (resp_off)
    );

    rsync_classify #(.STAT_W(STAT_W)) u_classify (
        .word_i (rd_data_i),
        .cls_o  (cls)
    );

    assign at_tail  = (resp_off == '0);
    assign last_off = &resp_off;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        launch     = 1'b0;
        kill       = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (start_i && irq_pend_i) begin
                    launch     = 1'b1;
                    ctl_d.ph   = PH_SCAN;
                    ctl_d.tail = tail_i;
                end
            end
            PH_SCAN: begin
                if (resp_vld) begin
                    if (at_tail) begin
                        // The tail must be empty for a resync to make sense.
                        if (!cls.empty) begin
                            kill        = 1'b1;
                            ctl_d.ph    = PH_IDLE;
                            ctl_d.done  = 1'b1;
                            ctl_d.found = 1'b0;
                            ctl_d.idx   = ctl_q.tail;
                        end
                    end else if (cls.full) begin
                        kill        = 1'b1;
                        ctl_d.ph    = PH_IDLE;
                        ctl_d.done  = 1'b1;
                        ctl_d.found = 1'b1;
                        ctl_d.idx   = ctl_q.tail + resp_off;
                    end else if (last_off) begin
                        kill        = 1'b1;
                        ctl_d.ph    = PH_IDLE;
                        ctl_d.done  = 1'b1;
                        ctl_d.found = 1'b0;
                        ctl_d.idx   = ctl_q.tail;
                    end
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign done_o    = ctl_q.done;
    assign found_o   = ctl_q.found;
    assign new_idx_o = ctl_q.idx;

    // R2
    no_unarmed_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_IDLE && start_i && !irq_pend_i) |=> !rd_en_o);

    // R3
    read_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (ctl_q.ph == PH_SCAN));

    // R5
    found_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && found_o) |-> (new_idx_o != ctl_q.tail));

    // R6
    miss_keeps_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> (new_idx_o == ctl_q.tail));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(found_o) && $stable(new_idx_o)));

endmodule

// File: tb/rsync_scan_bench.sv
module rsync_scan_bench;

    localparam logic [3:0] C_EMPTY  = 4'hA;
    localparam logic [3:0] C_FULL   = 4'h4;
    localparam logic [3:0] C_PARKED = 4'hF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_pend = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  tail = '0;
    logic        rd_en;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data = '0;
    logic        done;
    logic        found;
    logic [7:0]  new_idx;

    logic [31:0] mem [256];

    int checks = 0;
    int fails  = 0;
    int nread  = 0;
    int rd_bad = 0;
    int mon_tail = 0;

    always #2 clk = ~clk;

    rsync_scan u_rsync_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pend_i (irq_pend),
        .start_i    (start),
        .tail_i     (tail),
        .rd_en_o    (rd_en),
        .rd_addr_o  (rd_addr),
        .rd_data_i  (rd_data),
        .done_o     (done),
        .found_o    (found),
        .new_idx_o  (new_idx)
    );

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    always @(negedge clk) begin
        if (rd_en) begin
            if (int'(rd_addr) != (mon_tail + nread) % 256) rd_bad = rd_bad + 1;
            nread = nread + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [3:0] code);
        mem[idx] = {code, 28'h0800101 ^ 28'(idx)};
    endtask

    task automatic fill_all(input logic [3:0] code);
        for (int i = 0; i < 256; i++) put(i, code);
    endtask

    // Runs one scan and checks result, latency, read stream, pulse and hold.
    task automatic do_scan(input int t, input bit exp_found, input int exp_idx,
                           input int k, input string req,
                           input bit mid, input int mid_tail);
        int cyc;
        int exp_reads;
        bit seen;
        logic       f_keep;
        logic [7:0] i_keep;
        exp_reads = (k >= 255) ? 256 : k + 2;
        @(negedge clk);
        mon_tail = t; nread = 0; rd_bad = 0;
        irq_pend = 1'b1; start = 1'b1; tail = 8'(t);
        cyc = 0; seen = 1'b0;
        while (cyc < 400 && !seen) begin
            @(negedge clk);
            cyc++;
            start = (mid && cyc == 5);
            if (mid && cyc == 5) tail = 8'(mid_tail);
            if (done) seen = 1'b1;
        end
        chk(seen, req, "done seen", seen, 1);
        chk(cyc == k + 3, "R7", "done latency", cyc, k + 3);
        chk(found == exp_found, req, "found", found, exp_found);
        chk(int'(new_idx) == exp_idx, req, "new index", new_idx, exp_idx);
        chk(rd_bad == 0, "R3", "read address mismatches", rd_bad, 0);
        chk(nread == exp_reads, "R10", "read count", nread, exp_reads);
        f_keep = found; i_keep = new_idx;
        @(negedge clk);
        chk(!done, "R7", "done width", done, 0);
        chk(!rd_en, "R10", "read after decision", rd_en, 0);
        repeat (4) @(negedge clk);
        chk(found == f_keep && new_idx == i_keep && !done, "R9",
            "held index", new_idx, i_keep);
        irq_pend = 1'b0;
    endtask

    task automatic test_reset;
        repeat (3) @(negedge clk);
        chk(!done && !found && !rd_en && new_idx == 0, "R1", "reset outputs",
            {done, found, rd_en, new_idx}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done && !found && !rd_en && new_idx == 0, "R1", "after release",
            {done, found, rd_en, new_idx}, 0);
    endtask

    task automatic test_tail_not_empty;
        fill_all(C_EMPTY);
        put(33, C_FULL); put(34, C_FULL);
        do_scan(33, 1'b0, 33, 0, "R4", 1'b0, 0);
        put(60, C_PARKED); put(62, C_FULL);
        do_scan(60, 1'b0, 60, 0, "R4", 1'b0, 0);
    endtask

    task automatic test_holes;
        fill_all(C_EMPTY);
        put(21, C_PARKED); put(23, C_PARKED); put(25, C_FULL); put(26, C_FULL);
        do_scan(20, 1'b1, 25, 5, "R5", 1'b0, 0);
        fill_all(C_EMPTY);
        put(8, C_FULL);
        do_scan(7, 1'b1, 8, 1, "R5", 1'b0, 0);
    endtask

    task automatic test_wrap;
        fill_all(C_EMPTY);
        put(2, C_FULL); put(200, C_FULL);
        do_scan(250, 1'b1, 2, 8, "R3", 1'b0, 0);
    endtask

    task automatic test_last_slot;
        fill_all(C_EMPTY);
        put(9, C_FULL);
        do_scan(10, 1'b1, 9, 255, "R5", 1'b0, 0);
    endtask

    task automatic test_no_full;
        fill_all(C_EMPTY);
        put(150, C_PARKED);
        do_scan(100, 1'b0, 100, 255, "R6", 1'b0, 0);
    endtask

    task automatic test_busy_start;
        fill_all(C_EMPTY);
        put(140, C_FULL);
        do_scan(40, 1'b1, 140, 100, "R8", 1'b1, 200);
    endtask

    task automatic test_unarmed;
        logic       f_keep;
        logic [7:0] i_keep;
        int         rd_seen;
        int         dn_seen;
        fill_all(C_EMPTY);
        put(71, C_FULL);
        @(negedge clk);
        f_keep = found; i_keep = new_idx;
        irq_pend = 1'b0; start = 1'b1; tail = 8'd70;
        rd_seen = 0; dn_seen = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (rd_en) rd_seen++;
            if (done)  dn_seen++;
        end
        chk(rd_seen == 0, "R2", "reads without irq", rd_seen, 0);
        chk(dn_seen == 0, "R2", "done without irq", dn_seen, 0);
        chk(found == f_keep && new_idx == i_keep, "R2", "index without irq",
            new_idx, i_keep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        fill_all(C_EMPTY);
        test_reset();
        test_tail_not_empty();
        test_holes();
        test_wrap();
        test_unarmed();
        test_last_slot();
        test_no_full();
        test_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule